// File: doc/BRIEF.md
# I2C Bit-Rate Divider Search Engine

This engine chooses the timing fields for an I2C controller's SCL generator. A request gives the functional clock frequency and the desired SCL rate, both as 32-bit unsigned integers, with a one-cycle `start` strobe. The engine then works through power-of-two prescalers and clock-high counts. For each combination it computes the SCL rate that would result, using a fixed integer period formula. It keeps the combination whose absolute error is smallest.

Each candidate rate comes from one integer quotient. A single serial restoring divider, shared by all candidates, produces that quotient one bit per cycle. The search ends early when a candidate hits the target exactly. The engine then outputs the prescaler as a log2 code, together with clock-high, clock-low, setup/hold and data-valid counts derived from the winning clock-high value. A `done` pulse marks the result. If the clock frequency is zero, the engine returns at once with an error flag and all fields at zero.

Top module: `sclDivSearch`

## Requirements
- R1: Candidates are visited with the prescaler code c (prescaler 2^c) running 0 to 7 in the outer order and the clock-high count h running 1 to 31 in the inner order. The reported `preCode` is c and the reported `clkHi` is h of the winning candidate.
- R2: With F = `refFreq` and p = 2^c, the candidate rate is (F/p)/(6 + 2/p) for h = 1 and (F/p)/(3h + 2 + 2/p) for h ≥ 2. Every division is unsigned integer division that discards the remainder.
- R3: The best error starts at 0xFFFFFFFF and a candidate replaces the best only when |target − rate| is strictly smaller. If no candidate ever replaces it, the reported code and clock-high are both 0.
- R4: The search stops after the first candidate whose error is zero. Otherwise it stops after all 248 candidates. `done` is high in the cycle that follows the (34·n + 1)-th rising edge after the edge that accepted `start`, where n is the number of candidates evaluated.
- R5: When the winning clock-high is below 2, the engine reports `clkLo` = 3, `setHold` = 2 and `dataVld` = 1.
- R6: When the winning clock-high h is 2 or more, the engine reports `clkLo` = 2h, `setHold` = h and `dataVld` = h/2 (rounded down).
- R7: A request with `refFreq` = 0 produces `done` with `errFlag` = 1 and every field at 0, one cycle after `busy` rises. Any other request clears `errFlag`.
- R8: `done` is a single-cycle pulse. `errFlag` and all field outputs change only in the cycle in which `done` is high, and they hold their values until the next `done`.
- R9: `busy` is high from the cycle after `start` is accepted through the cycle before `done`, and it is low while `done` is high. A `start` that arrives while `busy` is high is ignored and does not change the running result.
- R10: After reset, `busy`, `done` and `errFlag` are 0 and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; accepted only while idle |
| refFreq | input | 32 | Functional clock frequency in Hz |
| targetRate | input | 32 | Desired SCL rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| errFlag | output | 1 | Last request had a zero clock frequency |
| preCode | output | 3 | log2 of the chosen prescaler |
| clkHi | output | 5 | Chosen clock-high count |
| clkLo | output | 6 | Derived clock-low count |
| setHold | output | 5 | Derived setup/hold count |
| dataVld | output | 4 | Derived data-valid count |

## Verification
The bench builds the engine with its default sizing: 32-bit operands, eight prescaler codes and clock-high counts up to 31. With these values a full search of 248 candidates can run inside the run budget, so requests that never match exactly are exercised end to end. So is a target of 0xFFFFFFFF, which no candidate ever improves on. The same sizing lets exact hits be placed at chosen points: on the first candidate, part-way through the second prescaler, and at a quotient of zero. Each of these gives a different `done` cycle, which the per-cycle model predicts.

// File: rtl/sclDivPkg.sv
package sclDivPkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch request, reset best tracking
    logic divInit;   // load divider with current candidate
    logic divStep;   // one restoring division step
    logic evalCand;  // compare quotient against best
    logic nextHi;    // advance clock-high count
    logic nextPre;   // advance prescaler code, clock-high back to 1
    logic finish;    // publish derived fields
    logic abort;     // publish zero-clock error
  } ctlStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_DIV, ST_CMP, ST_FIN, ST_ABT
  } ctlStateT;

endpackage

// File: rtl/sclDivCtl.sv
module sclDivCtl
  import sclDivPkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       clkZero,
  input  logic       exactHit,
  input  logic       lastHi,
  input  logic       lastPre,
  output ctlStrobeT  stb,
  output logic       busy
);
  localparam int CNT_W = $clog2(W);

  ctlStateT state, nextState;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stb = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.capture = 1'b1;
        nextState = clkZero ? ST_ABT : ST_INIT;
      end
      ST_INIT: begin
        stb.divInit = 1'b1;
        nextState = ST_DIV;
      end
      ST_DIV: begin
        stb.divStep = 1'b1;
        if (stepCnt == CNT_W'(W - 1)) nextState = ST_CMP;
      end
      ST_CMP: begin
        stb.evalCand = 1'b1;
        if (exactHit || (lastHi && lastPre)) nextState = ST_FIN;
        else begin
          if (lastHi) stb.nextPre = 1'b1;
          else        stb.nextHi  = 1'b1;
          nextState = ST_INIT;
        end
      end
      ST_FIN: begin
        stb.finish = 1'b1;
        nextState = ST_IDLE;
      end
      ST_ABT: begin
        stb.abort = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (stb.divInit)      stepCnt <= '0;
      else if (stb.divStep) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sclDivDp.sv
module sclDivDp
  import sclDivPkg::*;
#(
  parameter int W      = 32,
  parameter int PRE_N  = 8,
  parameter int HI_MAX = 31
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobeT                       stb,
  input  logic [W-1:0]                    refFreq,
  input  logic [W-1:0]                    targetRate,
  output logic                            clkZero,
  output logic                            exactHit,
  output logic                            lastHi,
  output logic                            lastPre,
  output logic                            done,
  output logic                            errFlag,
  output logic [$clog2(PRE_N)-1:0]        preCode,
  output logic [$clog2(HI_MAX+1)-1:0]     clkHi,
  output logic [$clog2(HI_MAX+1):0]       clkLo,
  output logic [$clog2(HI_MAX+1)-1:0]     setHold,
  output logic [$clog2(HI_MAX+1)-2:0]     dataVld
);
  localparam int PRE_W = $clog2(PRE_N);
  localparam int HI_W  = $clog2(HI_MAX + 1);
  localparam int LO_W  = HI_W + 1;
  localparam int DV_W  = HI_W - 1;
  localparam int DVR_W = $clog2(3 * HI_MAX + 5);

  logic [W-1:0]     refQ, tgtQ, bestErr, quoQ;
  logic [PRE_W-1:0] preIdx, bestPre;
  logic [HI_W-1:0]  hiCnt, bestHi;
  logic [DVR_W-1:0] remQ, divisorQ, baseDiv, extraDiv, divisorC;
  logic [DVR_W:0]   shl, diff;
  logic             ge;
  logic [W-1:0]     absErr;

  // period divisor for the current candidate
  always_comb begin
    if (hiCnt == HI_W'(1)) baseDiv = DVR_W'(6);
    else baseDiv = DVR_W'(3) * DVR_W'(hiCnt) + DVR_W'(2);
    if (preIdx == '0)              extraDiv = DVR_W'(2);
    else if (preIdx == PRE_W'(1))  extraDiv = DVR_W'(1);
    else                           extraDiv = '0;
    divisorC = baseDiv + extraDiv;
  end

  assign shl    = {remQ, quoQ[W-1]};
  assign diff   = shl - {1'b0, divisorQ};
  assign ge     = (shl >= {1'b0, divisorQ});
  assign absErr = (tgtQ > quoQ) ? (tgtQ - quoQ) : (quoQ - tgtQ);

  assign clkZero  = (refFreq == '0);
  assign exactHit = (absErr == '0);
  assign lastHi   = (hiCnt == HI_W'(HI_MAX));
  assign lastPre  = (preIdx == PRE_W'(PRE_N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ <= '0; tgtQ <= '0; bestErr <= '1; quoQ <= '0;
      preIdx <= '0; bestPre <= '0; hiCnt <= HI_W'(1); bestHi <= '0;
      remQ <= '0; divisorQ <= '0;
      done <= 1'b0; errFlag <= 1'b0;
      preCode <= '0; clkHi <= '0; clkLo <= '0; setHold <= '0; dataVld <= '0;
    end else begin
      done <= 1'b0;
      if (stb.capture) begin
        refQ    <= refFreq;
        tgtQ    <= targetRate;
        bestErr <= '1;
        bestPre <= '0;
        bestHi  <= '0;
        preIdx  <= '0;
        hiCnt   <= HI_W'(1);
      end
      if (stb.divInit) begin
        quoQ     <= refQ >> preIdx;
        remQ     <= '0;
        divisorQ <= divisorC;
      end
      if (stb.divStep) begin
        remQ <= ge ? diff[DVR_W-1:0] : shl[DVR_W-1:0];
        quoQ <= {quoQ[W-2:0], ge};
      end
      if (stb.evalCand && (absErr < bestErr)) begin
        bestErr <= absErr;
        bestPre <= preIdx;
        bestHi  <= hiCnt;
      end
      if (stb.nextHi) hiCnt <= hiCnt + 1'b1;
      if (stb.nextPre) begin
        preIdx <= preIdx + 1'b1;
        hiCnt  <= HI_W'(1);
      end
      if (stb.finish) begin
        done    <= 1'b1;
        errFlag <= 1'b0;
        preCode <= bestPre;
        clkHi   <= bestHi;
        if (bestHi < HI_W'(2)) begin
          clkLo   <= LO_W'(3);
          setHold <= HI_W'(2);
          dataVld <= DV_W'(1);
        end else begin
          clkLo   <= {bestHi, 1'b0};
          setHold <= bestHi;
          dataVld <= bestHi[HI_W-1:1];
        end
      end
      if (stb.abort) begin
        done    <= 1'b1;
        errFlag <= 1'b1;
        preCode <= '0; clkHi <= '0; clkLo <= '0; setHold <= '0; dataVld <= '0;
      end
    end
  end

endmodule

// File: rtl/sclDivSearch.sv
module sclDivSearch
  import sclDivPkg::*;
#(
  parameter int W      = 32,
  parameter int PRE_N  = 8,
  parameter int HI_MAX = 31
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [W-1:0]                refFreq,
  input  logic [W-1:0]                targetRate,
  output logic                        busy,
  output logic                        done,
  output logic                        errFlag,
  output logic [$clog2(PRE_N)-1:0]    preCode,
  output logic [$clog2(HI_MAX+1)-1:0] clkHi,
  output logic [$clog2(HI_MAX+1):0]   clkLo,
  output logic [$clog2(HI_MAX+1)-1:0] setHold,
  output logic [$clog2(HI_MAX+1)-2:0] dataVld
);
  ctlStrobeT stb;
  logic clkZero, exactHit, lastHi, lastPre;

  sclDivCtl #(.W(W)) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .clkZero(clkZero),
    .exactHit(exactHit), .lastHi(lastHi), .lastPre(lastPre),
    .stb(stb), .busy(busy)
  );

  sclDivDp #(.W(W), .PRE_N(PRE_N), .HI_MAX(HI_MAX)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .refFreq(refFreq), .targetRate(targetRate),
    .clkZero(clkZero), .exactHit(exactHit), .lastHi(lastHi), .lastPre(lastPre),
    .done(done), .errFlag(errFlag), .preCode(preCode), .clkHi(clkHi),
    .clkLo(clkLo), .setHold(setHold), .dataVld(dataVld)
  );

endmodule

// File: rtl/sclDivSearchChk.sv
module sclDivSearchChk #(
  parameter int W      = 32,
  parameter int PRE_N  = 8,
  parameter int HI_MAX = 31
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic [W-1:0]                refFreq,
  input logic                        busy,
  input logic                        done,
  input logic                        errFlag,
  input logic [$clog2(PRE_N)-1:0]    preCode,
  input logic [$clog2(HI_MAX+1)-1:0] clkHi,
  input logic [$clog2(HI_MAX+1):0]   clkLo,
  input logic [$clog2(HI_MAX+1)-1:0] setHold,
  input logic [$clog2(HI_MAX+1)-2:0] dataVld
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({errFlag, preCode, clkHi, clkLo, setHold, dataVld}));

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_zero_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && refFreq == '0) |=> busy ##1 (done && errFlag));

  p_abort_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> (preCode == '0 && clkHi == '0 && clkLo == '0
                           && setHold == '0 && dataVld == '0));

  p_small_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag && clkHi < 2) |-> (clkLo == 3 && setHold == 2 && dataVld == 1));

  p_derived_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag && clkHi >= 2) |->
      (clkLo == 2 * clkHi && setHold == clkHi && dataVld == clkHi / 2));

endmodule

bind sclDivSearch sclDivSearchChk #(.W(W), .PRE_N(PRE_N), .HI_MAX(HI_MAX)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .refFreq(refFreq), .busy(busy),
  .done(done), .errFlag(errFlag), .preCode(preCode), .clkHi(clkHi),
  .clkLo(clkLo), .setHold(setHold), .dataVld(dataVld)
);

// File: tb/sclDivSearch_tb_top.sv
module sclDivSearch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] refFreq = '0, targetRate = '0;
  logic busy, done, errFlag;
  logic [2:0] preCode;
  logic [4:0] clkHi, setHold;
  logic [5:0] clkLo;
  logic [3:0] dataVld;

  always #2 clk = ~clk;

  sclDivSearch dut_i (
    .clk(clk), .rstN(rstN), .start(start), .refFreq(refFreq), .targetRate(targetRate),
    .busy(busy), .done(done), .errFlag(errFlag), .preCode(preCode), .clkHi(clkHi),
    .clkLo(clkLo), .setHold(setHold), .dataVld(dataVld)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // held expectation of the result outputs
  logic       hErr = 0;
  logic [2:0] hCode = 0;
  logic [4:0] hHi = 0, hSh = 0;
  logic [5:0] hLo = 0;
  logic [3:0] hDv = 0;

  task automatic compareNow(input string tag, input logic eBusy, input logic eDone);
    nCmp++;
    if (busy !== eBusy || done !== eDone || errFlag !== hErr || preCode !== hCode ||
        clkHi !== hHi || clkLo !== hLo || setHold !== hSh || dataVld !== hDv) begin
      nBad++;
      $display("FAIL %s t=%0t actual busy=%b done=%b err=%b code=%0d hi=%0d lo=%0d sh=%0d dv=%0d expected busy=%b done=%b err=%b code=%0d hi=%0d lo=%0d sh=%0d dv=%0d",
        tag, $time, busy, done, errFlag, preCode, clkHi, clkLo, setHold, dataVld,
        eBusy, eDone, hErr, hCode, hHi, hLo, hSh, hDv);
    end
  endtask

  // behavioural search following R1..R4
  task automatic refModel(input logic [31:0] f, input logic [31:0] t,
                          output int nEval, output logic [2:0] code, output logic [4:0] hi);
    logic [31:0] err, r, a, pre;
    bit stop;
    err = '1; code = 0; hi = 0; nEval = 0; stop = 0;
    if (f == 0) return;
    for (int p = 0; p < 8 && !stop; p++) begin
      for (int h = 1; h < 32 && !stop; h++) begin
        nEval++;
        pre = 32'd1 << p;
        if (h == 1) r = (f / pre) / (32'd6 + 32'd2 / pre);
        else        r = (f / pre) / (32'd3 * h + 32'd2 + 32'd2 / pre);
        a = (t > r) ? t - r : r - t;
        if (a < err) begin
          err = a; code = p[2:0]; hi = h[4:0];
          if (a == 0) stop = 1;
        end
      end
    end
  endtask

  task automatic runCase(input logic [31:0] f, input logic [31:0] t,
                         input bit junk, input string tag);
    int nEval, total;
    logic [2:0] code;
    logic [4:0] hi;
    refModel(f, t, nEval, code, hi);
    total = 34 * nEval + 1;
    @(negedge clk);
    refFreq = f; targetRate = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= total; k++) begin
      if (junk && k == 4) begin start = 1'b1; refFreq = '0; targetRate = 32'h1234; end
      if (junk && k == 5) start = 1'b0;
      if (k == total) begin
        if (f == 0) begin
          hErr = 1; hCode = 0; hHi = 0; hLo = 0; hSh = 0; hDv = 0;
        end else begin
          hErr = 0; hCode = code; hHi = hi;
          if (hi < 2) begin hLo = 3; hSh = 2; hDv = 1; end
          else begin hLo = {hi, 1'b0}; hSh = hi; hDv = hi[4:1]; end
        end
      end
      compareNow(tag, k < total, k == total);
      if (k < total) @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      compareNow({tag, " hold R8"}, 1'b0, 1'b0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareNow("R10 reset", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    compareNow("R10 after reset", 1'b0, 1'b0);
    // R7: zero clock aborts
    runCase(32'd0, 32'd100000, 0, "R7 zero clock");
    // R5 R4: exact on first candidate (800/8 = 100)
    runCase(32'd800, 32'd100, 0, "R5 R4 first exact");
    // R6 R1 R2: exact at code 1, hi 5 (3600/2/18 = 100)
    runCase(32'd3600, 32'd100, 0, "R6 R1 R2 second prescaler");
    // R2 R4: target zero hit by a zero quotient
    runCase(32'd100, 32'd0, 0, "R2 R4 zero quotient");
    // R3: all-ones target never improves on the initial error
    runCase(32'd1, 32'hFFFF_FFFF, 0, "R3 never replaced");
    // R1 R3 R6: full search with a realistic clock; R9 junk start mid-run
    runCase(32'd24_000_000, 32'd100_000, 1, "R9 R1 R3 ignored start");
    // R2 R6: largest clock
    runCase(32'hFFFF_FFFF, 32'd400_000, 0, "R2 R6 large clock");
    // R7: error flag cleared by the next good request
    runCase(32'd0, 32'd5, 0, "R7 abort again");
    runCase(32'd48_000_000, 32'd1_000_000, 0, "R7 R6 clears error");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule